// File: doc/BRIEF.md
# Packed Integer-to-Float Stream Converter

This block sits between a 32-bit host data path and a linear array of floating-point cells. On the way in it accepts one host word that carries either four 8-bit or two 16-bit integers, splits the word into its lanes, and turns each lane into an IEEE single-precision float. The float crosses to the array over a 16-bit channel in two beats. On the way back it takes single-precision results from the array, converts each one to an integer of the selected lane size, and packs consecutive results into one 32-bit host word. The host therefore moves a quarter of the array's word rate in 8-bit mode and half of it in 16-bit mode.

Each direction has its own lane-size and signedness selects. The selects are captured with the first lane of a word and hold for the rest of that word. Both sides use valid/ready handshakes, and the two directions run independently of each other.

Top module: `packed_flt_bridge`

## Requirements
- R1: While reset is held and just after it ends, `host_in_ready` and `lane_in_ready` are 1, and `lane_out_valid` and `host_out_valid` are 0.
- R2: With `in_wide`=0, an accepted host word yields four floats in the order bits 7:0, 15:8, 23:16, 31:24.
- R3: With `in_wide`=1, an accepted host word yields two floats in the order bits 15:0, then 31:16.
- R4: With `in_signed`=1 each inbound lane is read as two's complement; with 0 it is read as unsigned.
- R5: Inbound conversion is exact. A zero lane gives 0x00000000. A non-zero lane gives sign, exponent 127 plus the index of the leading one, and the bits below the leading one as mantissa.
- R6: Each float leaves on `lane_out_half` as bits 15:0 with `lane_out_phase`=0, followed by bits 31:16 with `lane_out_phase`=1.
- R7: After a host word is accepted, `host_in_ready` stays 0 until the last float of that word has been taken for transmission.
- R8: While `lane_out_valid`=1 and `lane_out_ready`=0, the half and the phase do not change.
- R9: Outbound conversion truncates toward zero, so magnitudes below 1.0 give 0.
- R10: Outbound results saturate to the lane range: -128..127 or 0..255 for 8 bits, and -32768..32767 or 0..65535 for 16 bits. Infinities are included. Negative values give 0 in unsigned mode.
- R11: A NaN input (exponent all ones, mantissa non-zero) gives 0.
- R12: The first returned float goes into the lowest lane. A host word is presented after four results in 8-bit mode (`out_wide`=0) or two in 16-bit mode (`out_wide`=1).
- R13: While `host_out_valid`=1 and `host_out_ready`=0, the word holds steady and `lane_in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_in_valid | input | 1 | Inbound host word present |
| host_in_ready | output | 1 | Inbound host word taken |
| host_in_word | input | 32 | Packed integers from host |
| in_wide | input | 1 | Inbound lane size: 0 = 8-bit, 1 = 16-bit |
| in_signed | input | 1 | Inbound lanes are two's complement |
| lane_out_valid | output | 1 | Half-float beat toward the array present |
| lane_out_ready | input | 1 | Array accepts the beat |
| lane_out_half | output | 16 | One half of a float |
| lane_out_phase | output | 1 | 0 = low half, 1 = high half |
| lane_in_valid | input | 1 | Float result from array present |
| lane_in_ready | output | 1 | Float result taken |
| lane_in_flt | input | 32 | Single-precision result |
| host_out_valid | output | 1 | Packed host word present |
| host_out_ready | input | 1 | Host accepts the word |
| host_out_word | output | 32 | Packed integers to host |
| out_wide | input | 1 | Outbound lane size: 0 = 8-bit, 1 = 16-bit |
| out_signed | input | 1 | Outbound lanes are two's complement |

## Verification
The unpack-and-convert path and the convert-and-repack path share no state, so a half-float beat toward the array and a float taken from the array can fall in the same cycle. A clash there would show up as corruption of one of the two streams. The bench starts both directions together, each with its own mode sequence. Ready stalls on both the array side and the host side keep their accept cycles moving against each other. Every beat and every packed word is compared in order against expectations built from integers. The return stream is fed floats made from known integers, so each packed word must match the integers it came from exactly.

// File: rtl/pkb_pkg.sv
package pkb_pkg;

   localparam int HOST_W = 32;
   localparam int FLT_W  = 32;
   localparam int VAL_W  = 17;
   localparam int BIAS   = 127;
   localparam int MAN_W  = 23;

   // exact conversion of a 17-bit two's complement value (|v| <= 65535)
   function automatic logic [31:0] int_to_flt(input logic [VAL_W-1:0] v);
      logic             neg;
      logic [VAL_W-1:0] mag;
      logic [39:0]      tmp;
      logic [31:0]      r;
      int               lead;
      neg  = v[VAL_W-1];
      mag  = neg ? (VAL_W'(0) - v) : v;
      lead = 0;
      for (int i = 0; i < VAL_W; i++)
         if (mag[i]) lead = i;
      tmp = 40'(mag) << (MAN_W - lead);
      if (mag == '0) r = '0;
      else           r = {neg, 8'(BIAS + lead), 23'(tmp)};
      return r;
   endfunction

   // truncating, saturating conversion; result lies in the low 8 or 16 bits
   function automatic logic [15:0] flt_to_int(input logic [31:0] f,
                                              input logic        wide,
                                              input logic        sgn);
      logic [7:0]       e;
      logic [23:0]      sig;
      logic [VAL_W-1:0] mag;
      logic [VAL_W-1:0] pos_max;
      logic [VAL_W-1:0] neg_lim;
      logic             big;
      logic             nan;
      logic [15:0]      r;
      e   = f[30:23];
      sig = {1'b1, f[22:0]};
      nan = (e == 8'hFF) && (f[22:0] != '0);
      big = 1'b0;
      mag = '0;
      if (int'(e) >= BIAS + 16) big = 1'b1;
      else if (int'(e) >= BIAS) mag = VAL_W'(sig >> (BIAS + MAN_W - int'(e)));
      if (sgn) begin
         pos_max = wide ? VAL_W'(32767) : VAL_W'(127);
         neg_lim = wide ? VAL_W'(32768) : VAL_W'(128);
      end else begin
         pos_max = wide ? VAL_W'(65535) : VAL_W'(255);
         neg_lim = '0;
      end
      if (nan)                        r = '0;
      else if (f[31]) begin
         if (big || mag > neg_lim)    r = 16'(VAL_W'(0) - neg_lim);
         else                         r = 16'(VAL_W'(0) - mag);
      end else begin
         if (big || mag > pos_max)    r = 16'(pos_max);
         else                         r = 16'(mag);
      end
      return r;
   endfunction

endpackage

// File: rtl/pkb_unpack.sv
module pkb_unpack
   import pkb_pkg::*;
#(
   parameter int WORD_W = HOST_W,
   parameter int F_W    = FLT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WORD_W-1:0] in_data,
   input  logic             in_wide,
   input  logic             in_sgn,
   output logic             f_valid,
   input  logic             f_ready,
   output logic [F_W-1:0]   f_data
);
   localparam int NAR_N = 4;
   localparam int WID_N = 2;
   localparam int NAR_W = WORD_W / NAR_N;
   localparam int WID_W = WORD_W / WID_N;
   localparam int IDX_W = $clog2(NAR_N);

   if (WORD_W != 32) begin : g_bad_word
      $error("pkb_unpack: WORD_W must be 32");
   end
   if (F_W != 32) begin : g_bad_flt
      $error("pkb_unpack: F_W must be 32");
   end

   logic [WORD_W-1:0] word_q;
   logic              wide_q, sgn_q, busy_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  last_idx;
   logic [NAR_W-1:0]  nar [NAR_N];
   logic [WID_W-1:0]  wid [WID_N];
   logic [NAR_W-1:0]  raw_n;
   logic [WID_W-1:0]  raw_w;
   logic [VAL_W-1:0]  val;

   for (genvar g = 0; g < NAR_N; g++) begin : g_nar
      assign nar[g] = word_q[g*NAR_W +: NAR_W];
   end
   for (genvar g = 0; g < WID_N; g++) begin : g_wid
      assign wid[g] = word_q[g*WID_W +: WID_W];
   end

   assign last_idx = wide_q ? IDX_W'(WID_N - 1) : IDX_W'(NAR_N - 1);
   assign in_ready = !busy_q;
   assign f_valid  = busy_q;
   assign raw_n    = nar[idx_q];
   assign raw_w    = wid[idx_q[0]];

   always_comb begin
      if (wide_q) val = {{(VAL_W-WID_W){sgn_q & raw_w[WID_W-1]}}, raw_w};
      else        val = {{(VAL_W-NAR_W){sgn_q & raw_n[NAR_W-1]}}, raw_n};
   end

   assign f_data = int_to_flt(val);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         wide_q <= 1'b0;
         sgn_q  <= 1'b0;
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (in_valid && in_ready) begin
         word_q <= in_data;
         wide_q <= in_wide;
         sgn_q  <= in_sgn;
         busy_q <= 1'b1;
         idx_q  <= '0;
      end else if (busy_q && f_ready) begin
         if (idx_q == last_idx) busy_q <= 1'b0;
         else                   idx_q  <= idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/pkb_halftx.sv
module pkb_halftx
   import pkb_pkg::*;
#(
   parameter int F_W = FLT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             f_valid,
   output logic             f_ready,
   input  logic [F_W-1:0]   f_data,
   output logic             o_valid,
   input  logic             o_ready,
   output logic [F_W/2-1:0] o_half,
   output logic             o_phase
);
   localparam int HALF_W = F_W / 2;

   if (F_W % 2 != 0) begin : g_bad_flt
      $error("pkb_halftx: F_W must be even");
   end

   logic [F_W-1:0] hold_q;
   logic           full_q, phase_q;

   assign f_ready = !full_q || (phase_q && o_ready);
   assign o_valid = full_q;
   assign o_phase = phase_q;
   assign o_half  = phase_q ? hold_q[F_W-1 -: HALF_W] : hold_q[HALF_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         full_q  <= 1'b0;
         phase_q <= 1'b0;
      end else if (full_q && o_ready && !phase_q) begin
         phase_q <= 1'b1;
      end else if (f_ready) begin
         full_q  <= f_valid;
         phase_q <= 1'b0;
         if (f_valid) hold_q <= f_data;
      end
   end
endmodule

// File: rtl/pkb_repack.sv
module pkb_repack
   import pkb_pkg::*;
#(
   parameter int WORD_W = HOST_W,
   parameter int F_W    = FLT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_valid,
   output logic              i_ready,
   input  logic [F_W-1:0]    i_data,
   input  logic              wide,
   input  logic              sgn,
   output logic              o_valid,
   input  logic              o_ready,
   output logic [WORD_W-1:0] o_data
);
   localparam int NAR_N = 4;
   localparam int WID_N = 2;
   localparam int NAR_W = WORD_W / NAR_N;
   localparam int WID_W = WORD_W / WID_N;
   localparam int IDX_W = $clog2(NAR_N);

   if (WORD_W != 32 || F_W != 32) begin : g_bad_width
      $error("pkb_repack: WORD_W and F_W must be 32");
   end

   logic [WORD_W-1:0] acc_q, out_q, merged;
   logic [IDX_W-1:0]  idx_q;
   logic              wide_q, sgn_q, valid_q;
   logic              cur_wide, cur_sgn, last;
   logic [15:0]       conv;

   assign cur_wide = (idx_q == '0) ? wide : wide_q;
   assign cur_sgn  = (idx_q == '0) ? sgn  : sgn_q;
   assign conv     = flt_to_int(i_data, cur_wide, cur_sgn);
   assign last     = cur_wide ? (idx_q == IDX_W'(WID_N - 1)) : (idx_q == IDX_W'(NAR_N - 1));
   assign i_ready  = !valid_q;
   assign o_valid  = valid_q;
   assign o_data   = out_q;

   always_comb begin
      merged = acc_q;
      if (cur_wide) merged[int'(idx_q[0])*WID_W +: WID_W] = conv[WID_W-1:0];
      else          merged[int'(idx_q)*NAR_W +: NAR_W]    = conv[NAR_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         out_q   <= '0;
         idx_q   <= '0;
         wide_q  <= 1'b0;
         sgn_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         if (valid_q && o_ready) valid_q <= 1'b0;
         if (i_valid && i_ready) begin
            wide_q <= cur_wide;
            sgn_q  <= cur_sgn;
            if (last) begin
               out_q   <= merged;
               valid_q <= 1'b1;
               acc_q   <= '0;
               idx_q   <= '0;
            end else begin
               acc_q <= merged;
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/packed_flt_bridge.sv
module packed_flt_bridge
   import pkb_pkg::*;
#(
   parameter int WORD_W = HOST_W,
   parameter int F_W    = FLT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_in_valid,
   output logic              host_in_ready,
   input  logic [WORD_W-1:0] host_in_word,
   input  logic              in_wide,
   input  logic              in_signed,
   output logic              lane_out_valid,
   input  logic              lane_out_ready,
   output logic [F_W/2-1:0]  lane_out_half,
   output logic              lane_out_phase,
   input  logic              lane_in_valid,
   output logic              lane_in_ready,
   input  logic [F_W-1:0]    lane_in_flt,
   output logic              host_out_valid,
   input  logic              host_out_ready,
   output logic [WORD_W-1:0] host_out_word,
   input  logic              out_wide,
   input  logic              out_signed
);
   logic           flt_valid, flt_ready;
   logic [F_W-1:0] flt_data;

   pkb_unpack #(.WORD_W(WORD_W), .F_W(F_W)) u_unpack (
      .clk(clk), .rst_n(rst_n),
      .in_valid(host_in_valid), .in_ready(host_in_ready), .in_data(host_in_word),
      .in_wide(in_wide), .in_sgn(in_signed),
      .f_valid(flt_valid), .f_ready(flt_ready), .f_data(flt_data)
   );

   pkb_halftx #(.F_W(F_W)) u_halftx (
      .clk(clk), .rst_n(rst_n),
      .f_valid(flt_valid), .f_ready(flt_ready), .f_data(flt_data),
      .o_valid(lane_out_valid), .o_ready(lane_out_ready),
      .o_half(lane_out_half), .o_phase(lane_out_phase)
   );

   pkb_repack #(.WORD_W(WORD_W), .F_W(F_W)) u_repack (
      .clk(clk), .rst_n(rst_n),
      .i_valid(lane_in_valid), .i_ready(lane_in_ready), .i_data(lane_in_flt),
      .wide(out_wide), .sgn(out_signed),
      .o_valid(host_out_valid), .o_ready(host_out_ready), .o_data(host_out_word)
   );
endmodule

// File: rtl/packed_flt_bridge_chk.sv
module packed_flt_bridge_chk #(
   parameter int WORD_W = 32,
   parameter int F_W    = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_in_valid,
   input logic              host_in_ready,
   input logic              lane_out_valid,
   input logic              lane_out_ready,
   input logic [F_W/2-1:0]  lane_out_half,
   input logic              lane_out_phase,
   input logic              lane_in_ready,
   input logic              host_out_valid,
   input logic              host_out_ready,
   input logic [WORD_W-1:0] host_out_word
);
   AST_HOST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (host_in_valid && host_in_ready) |=> !host_in_ready); // R7
   AST_LANE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_out_valid && !lane_out_ready) |=>
         (lane_out_valid && $stable(lane_out_half) && $stable(lane_out_phase))); // R8
   AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_out_valid && lane_out_ready && !lane_out_phase) |=> (lane_out_valid && lane_out_phase)); // R6
   AST_LOW_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_out_valid && lane_out_ready && lane_out_phase) |=> !lane_out_phase); // R6
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (host_out_valid && !host_out_ready) |=> (host_out_valid && $stable(host_out_word))); // R13
   AST_RETURN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      host_out_valid |-> !lane_in_ready); // R13
endmodule

bind packed_flt_bridge packed_flt_bridge_chk #(.WORD_W(WORD_W), .F_W(F_W)) u_chk (.*);

// File: tb/packed_flt_bridge_tb.sv
module packed_flt_bridge_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_in_valid = 1'b0;
   logic        host_in_ready;
   logic [31:0] host_in_word = '0;
   logic        in_wide = 1'b0, in_signed = 1'b0;
   logic        lane_out_valid;
   logic        lane_out_ready = 1'b1;
   logic [15:0] lane_out_half;
   logic        lane_out_phase;
   logic        lane_in_valid = 1'b0;
   logic        lane_in_ready;
   logic [31:0] lane_in_flt = '0;
   logic        host_out_valid;
   logic        host_out_ready = 1'b1;
   logic [31:0] host_out_word;
   logic        out_wide = 1'b0, out_signed = 1'b0;

   packed_flt_bridge u_dut (.*);

   always #4 clk = ~clk;   // 125 MHz

   int compared = 0, mismatched = 0;
   bit done = 0, stall_en = 0, hold_out = 0;
   int cyc = 0;
   logic [16:0] exp_half[$];
   string       half_tag[$];
   logic [31:0] exp_word[$];
   string       word_tag[$];
   logic [31:0] lfsr = 32'h1ACE_B00C;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_flt(input int v);
      logic [63:0] d;
      int ex;
      if (v == 0) return 32'h0;
      d  = $realtobits(real'(v));
      ex = int'(d[62:52]) - 896;
      return {d[63], ex[7:0], d[51:29]};
   endfunction

   function automatic int lane_val(input logic [31:0] w, input bit wd, input bit sg, input int k);
      if (wd) return sg ? int'($signed(w[k*16 +: 16])) : int'(w[k*16 +: 16]);
      return sg ? int'($signed(w[k*8 +: 8])) : int'(w[k*8 +: 8]);
   endfunction

   function automatic logic [31:0] next_rand(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      return y ^ (y << 5);
   endfunction

   // ready generators, changed just after the rising edge
   initial forever begin
      @(posedge clk); #1;
      cyc++;
      lane_out_ready = stall_en ? (cyc % 4 != 2) : 1'b1;
      host_out_ready = hold_out ? 1'b0 : (stall_en ? (cyc % 3 != 1) : 1'b1);
   end

   // inbound driver (R2, R3, R4, R5, R7)
   task automatic put_host(input logic [31:0] w, input bit wd, input bit sg, input string tag);
      logic [31:0] f;
      for (int k = 0; k < (wd ? 2 : 4); k++) begin
         f = ref_flt(lane_val(w, wd, sg, k));
         exp_half.push_back({1'b0, f[15:0]});  half_tag.push_back(tag);
         exp_half.push_back({1'b1, f[31:16]}); half_tag.push_back(tag);
      end
      @(posedge clk); #1;
      host_in_valid = 1'b1; host_in_word = w; in_wide = wd; in_signed = sg;
      do @(negedge clk); while (!host_in_ready);
      @(posedge clk); #1;
      host_in_valid = 1'b0;
      @(negedge clk);
      chk(!host_in_ready, "R7 host_in_ready after accept", {31'b0, host_in_ready}, 32'h0);
   endtask

   // outbound driver
   task automatic put_flt(input logic [31:0] f);
      @(posedge clk); #1;
      lane_in_valid = 1'b1; lane_in_flt = f;
      do @(negedge clk); while (!lane_in_ready);
      @(posedge clk); #1;
      lane_in_valid = 1'b0;
   endtask

   task automatic ret_word(input bit wd, input bit sg, input logic [31:0] f0, input logic [31:0] f1,
                           input logic [31:0] f2, input logic [31:0] f3, input logic [31:0] expw,
                           input string tag);
      exp_word.push_back(expw); word_tag.push_back(tag);
      @(posedge clk); #1;
      out_wide = wd; out_signed = sg;
      put_flt(f0); put_flt(f1);
      if (!wd) begin put_flt(f2); put_flt(f3); end
   endtask

   // monitors (sample at falling edge)
   logic [16:0] prev_beat;
   bit          prev_stalled = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stalled)
            chk(lane_out_valid && {lane_out_phase, lane_out_half} == prev_beat,
                "R8 stalled beat held", {15'b0, lane_out_phase, lane_out_half}, {15'b0, prev_beat});
         prev_stalled = lane_out_valid && !lane_out_ready;
         prev_beat    = {lane_out_phase, lane_out_half};
         if (lane_out_valid && lane_out_ready) begin
            if (exp_half.size() == 0)
               chk(0, "R2 unexpected beat", {15'b0, lane_out_phase, lane_out_half}, 32'h0);
            else begin
               logic [16:0] e;
               string t;
               e = exp_half.pop_front(); t = half_tag.pop_front();
               chk(lane_out_phase == e[16], "R6 phase", {31'b0, lane_out_phase}, {31'b0, e[16]});
               chk(lane_out_half == e[15:0], t, {16'b0, lane_out_half}, {16'b0, e[15:0]});
            end
         end
         if (host_out_valid && host_out_ready) begin
            if (exp_word.size() == 0) chk(0, "R12 unexpected word", host_out_word, 32'h0);
            else begin
               logic [31:0] e;
               string t;
               e = exp_word.pop_front(); t = word_tag.pop_front();
               chk(host_out_word == e, t, host_out_word, e);
            end
         end
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL R7 watchdog expired: actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      logic [31:0] w;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(host_in_ready && lane_in_ready, "R1 readies in reset",
          {30'b0, host_in_ready, lane_in_ready}, 32'h3);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      chk(!lane_out_valid && !host_out_valid, "R1 valids after reset",
          {30'b0, lane_out_valid, host_out_valid}, 32'h0);
      chk(host_in_ready, "R1 host_in_ready after reset", {31'b0, host_in_ready}, 32'h1);

      // inbound directed
      put_host(32'h80FF_0100, 0, 0, "R2 narrow unsigned order");
      put_host(32'h80FF_0100, 0, 1, "R4 narrow signed");
      put_host(32'h8000_7FFF, 1, 1, "R3 wide signed order");
      put_host(32'hFFFF_0003, 1, 0, "R4 wide unsigned");
      put_host(32'h0000_0000, 1, 1, "R5 zero maps to +0");
      put_host(32'h0000_4001, 1, 0, "R5 normalizer");

      // outbound directed
      ret_word(0, 1, 32'h4070_0000, 32'hC020_0000, 32'h4348_0000, 32'hC47A_0000,
               32'h807F_FE03, "R9 truncate and R10 saturate narrow signed");
      ret_word(0, 0, 32'hC0A0_0000, 32'h437F_E666, 32'h7FC0_0000, 32'h7F80_0000,
               32'hFF00_FF00, "R11 NaN and R10 unsigned limits");
      ret_word(1, 1, 32'h3F7F_BE77, 32'hC700_0000, 32'h0, 32'h0,
               32'h8000_0000, "R9 below one and wide minimum");
      ret_word(1, 1, 32'h5015_02F9, 32'hBF00_0000, 32'h0, 32'h0,
               32'h0000_7FFF, "R10 wide signed saturate");
      ret_word(1, 0, 32'h477F_FF00, 32'h4788_B800, 32'h0, 32'h0,
               32'hFFFF_FFFF, "R10 wide unsigned saturate");

      // R13: host side stalls the return path
      hold_out = 1;
      ret_word(0, 0, ref_flt(1), ref_flt(2), ref_flt(3), ref_flt(4), 32'h0403_0201, "R12 lane order");
      repeat (2) @(negedge clk);
      w = host_out_word;
      chk(host_out_valid && !lane_in_ready, "R13 blocked while word pending",
          {30'b0, host_out_valid, lane_in_ready}, 32'h2);
      repeat (3) @(negedge clk);
      chk(host_out_word == w && host_out_valid, "R13 word held", host_out_word, w);
      hold_out = 0;

      // both directions at once, with stalls
      stall_en = 1;
      fork
         begin
            logic [31:0] r = 32'h5EED_0001;
            for (int n = 0; n < 30; n++) begin
               r = next_rand(r);
               put_host(r, r[3], r[7], "R2 concurrent inbound");
            end
         end
         begin
            for (int n = 0; n < 30; n++) begin
               bit wd, sg;
               lfsr = next_rand(lfsr);
               wd = lfsr[5]; sg = lfsr[9];
               ret_word(wd, sg,
                        ref_flt(lane_val(lfsr, wd, sg, 0)), ref_flt(lane_val(lfsr, wd, sg, 1)),
                        ref_flt(lane_val(lfsr, wd, sg, 2)), ref_flt(lane_val(lfsr, wd, sg, 3)),
                        lfsr, "R12 concurrent repack");
            end
         end
      join
      stall_en = 0;

      for (int n = 0; n < 400 && (exp_half.size() != 0 || exp_word.size() != 0); n++)
         @(negedge clk);
      chk(exp_half.size() == 0, "R6 beats left over", exp_half.size(), 32'h0);
      chk(exp_word.size() == 0, "R12 words left over", exp_word.size(), 32'h0);
      done = 1;
      summary();
   end
endmodule